// File: doc/BRIEF.md
# Base-16 Chain-Position Digit Generator for One-Time Hash Signatures

This block turns a 256-bit message digest into the sequence of base-16 digits that a Winternitz-style one-time signature engine uses to decide how far along each hash chain to step. It produces 67 digits in all. The first 64 are the message nibbles, most significant nibble first. The last 3 encode a checksum over those nibbles, and the checksum makes sure that any forgery which raises a message digit has to lower a checksum digit.

A controller first loads a digest while the block is idle, then pulses start. The block adds the complement of one message nibble per clock on a 16-bit accumulator. It does this by rotating a circular 256-bit register, so after 64 clocks the register is back to its original contents. The checksum is shifted left by four bits and its upper three nibbles are kept in a 12-bit circular register. The block then offers digits one at a time on a valid/ready output stream. Each accepted digit rotates the register that holds it, so no array of digits is ever stored. Once digit 66 is accepted, the block goes idle again.

Stream rules: `dig_valid` stays high and `dig_data` and `dig_idx` stay constant for as long as `dig_ready` is low. A digit is transferred on any clock edge where both `dig_valid` and `dig_ready` are high. The consumer may hold `dig_ready` low for any length of time. `load` and `start` are plain control pulses and are sampled only while `busy` is low.

Top module: `wots_basew_digits`

## Requirements
- R1: After reset, `busy`, `dig_valid`, `dig_idx` and `dig_data` are all 0. `dig_idx` and `dig_data` read 0 whenever `dig_valid` is low.
- R2: `load` while idle captures `digest`. `start` while idle raises `busy` at the next edge. The first digit becomes valid exactly 64 clock edges after the edge that sampled `start`.
- R3: The checksum is the sum of (15 - n) over the 64 message nibbles n. Its maximum of 960 (all-zero digest) fits the 16-bit accumulator without overflow.
- R4: Digit i, for i in 0..63, equals `digest[255-4*i -: 4]`, so the most significant nibble comes first.
- R5: Digits 64, 65 and 66 are bits [15:12], [11:8] and [7:4] of the 16-bit checksum shifted left by 4. Equivalently they are checksum bits [11:8], [7:4] and [3:0].
- R6: While `dig_valid` is high and `dig_ready` is low, `dig_data` and `dig_idx` hold their values. Each handshake advances `dig_idx` by exactly one.
- R7: After the handshake on index 66, `dig_valid` and `busy` are low at the next edge and stay low until a new `start`.
- R8: While `busy` is high, `load` and `start` have no effect. The accumulation latency and all remaining digits still come from the digest captured before the run.
- R9: A `start` without a new `load` after a completed run replays the same 67 digits.
- R10: `load` and `start` in the same idle cycle run on the newly presented digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `digest` when idle |
| digest | input | 256 | Message digest to encode |
| start | input | 1 | Begin checksum accumulation when idle |
| busy | output | 1 | High from start until the last digit is accepted |
| dig_ready | input | 1 | Consumer accepts the offered digit |
| dig_valid | output | 1 | A digit is offered |
| dig_data | output | 4 | Offered base-16 digit |
| dig_idx | output | 7 | Position of the offered digit, 0..66 |

## Verification
Damage to the accumulator or to the checksum slice shows up only in the last three digits, and only after the whole message has been drained. The bench therefore checks those three digits for digests at both ends of the checksum range and for a mixed pattern. A ring that rotates by the wrong amount, or that fails to return to its starting state, corrupts message digits straight away, or corrupts a replayed run. A slip in the controller's counter shows up on the first handshake as a skipped or repeated index, or as valid arriving one cycle early or late.

// File: rtl/wots_digit_pkg.sv
package wots_digit_pkg;

  localparam int DEF_LOG_W  = 4;
  localparam int DEF_LEN1   = 64;
  localparam int DEF_LEN2   = 3;
  localparam int DEF_CSUM_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_EMIT = 2'd2
  } dg_state_e;

endpackage

// File: rtl/dg_ring.sv
module dg_ring #(
  parameter int WIDTH = 256,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             rot,
  output logic [STEP-1:0]  head
);

  localparam int REST = WIDTH - STEP;

  logic [WIDTH-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (ld) begin
      word <= ld_val;
    end else if (rot) begin
      word <= {word[REST-1:0], word[WIDTH-1 -: STEP]};
    end
  end

  assign head = word[WIDTH-1 -: STEP];

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !rot) |=> $stable(word)); // R8

endmodule

// File: rtl/dg_csum_acc.sv
module dg_csum_acc #(
  parameter int DIG_W   = 4,
  parameter int CSUM_W  = 16,
  parameter int MAX_SUM = 960
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DIG_W-1:0]  nib,
  output logic [CSUM_W-1:0] sum_nxt
);

  logic [CSUM_W-1:0] sum;
  logic [DIG_W-1:0]  inv;

  always_comb begin
    inv     = ~nib;
    sum_nxt = sum + {{(CSUM_W-DIG_W){1'b0}}, inv};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
    end else if (clr) begin
      sum <= '0;
    end else if (en) begin
      sum <= sum_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= CSUM_W'(MAX_SUM)); // R3

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0)); // R2

endmodule

// File: rtl/dg_ctrl.sv
module dg_ctrl
  import wots_digit_pkg::*;
#(
  parameter int LEN1  = 64,
  parameter int NDIG  = 67,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             start,
  input  logic             next,
  output logic             busy,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             msg_ld,
  output logic             msg_rot,
  output logic             cks_ld,
  output logic             cks_rot,
  output logic             cks_sel
);

  localparam logic [IDX_W-1:0] ACC_LAST = IDX_W'(LEN1 - 1);
  localparam logic [IDX_W-1:0] CKS_FST  = IDX_W'(LEN1);
  localparam logic [IDX_W-1:0] DIG_LAST = IDX_W'(NDIG - 1);

  dg_state_e        state;
  logic [IDX_W-1:0] cnt;

  always_comb begin
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    msg_ld  = 1'b0;
    msg_rot = 1'b0;
    cks_ld  = 1'b0;
    cks_rot = 1'b0;
    cks_sel = 1'b0;
    valid   = 1'b0;
    case (state)
      ST_IDLE: begin
        msg_ld  = load;
        acc_clr = start;
      end
      ST_ACC: begin
        acc_en  = 1'b1;
        msg_rot = 1'b1;
        cks_ld  = (cnt == ACC_LAST);
      end
      ST_EMIT: begin
        valid   = 1'b1;
        cks_sel = (cnt >= CKS_FST);
        cks_rot = next && cks_sel;
        msg_rot = next && !cks_sel;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ACC;
            cnt   <= '0;
          end
        end
        ST_ACC: begin
          if (cnt == ACC_LAST) begin
            state <= ST_EMIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + IDX_W'(1);
          end
        end
        ST_EMIT: begin
          if (next) begin
            if (cnt == DIG_LAST) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + IDX_W'(1);
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign idx  = (state == ST_EMIT) ? cnt : '0;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (idx <= DIG_LAST)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !next) |=> (valid && $stable(idx))); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && next && idx != DIG_LAST) |=> (valid && idx == $past(idx) + IDX_W'(1))); // R6

  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && next && idx == DIG_LAST) |=> (!valid && !busy)); // R7

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy); // R8

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !valid)); // R2

endmodule

// File: rtl/wots_basew_digits.sv
module wots_basew_digits
  import wots_digit_pkg::*;
#(
  parameter int  LOG_W  = DEF_LOG_W,
  parameter int  LEN1   = DEF_LEN1,
  parameter int  LEN2   = DEF_LEN2,
  parameter int  CSUM_W = DEF_CSUM_W,
  localparam int MSG_W  = LEN1 * LOG_W,
  localparam int NDIG   = LEN1 + LEN2,
  localparam int IDX_W  = $clog2(NDIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] digest,
  input  logic             start,
  output logic             busy,
  input  logic             dig_ready,
  output logic             dig_valid,
  output logic [LOG_W-1:0] dig_data,
  output logic [IDX_W-1:0] dig_idx
);

  localparam int CKS_W      = LEN2 * LOG_W;
  localparam int CSUM_SHIFT = 8 - ((LEN2 * LOG_W) % 8);
  localparam int DIG_MAX    = (1 << LOG_W) - 1;
  localparam int CSUM_MAX   = LEN1 * DIG_MAX;

  logic              acc_clr, acc_en, msg_ld, msg_rot, cks_ld, cks_rot, cks_sel;
  logic [CSUM_W-1:0] sum_nxt;
  logic [CSUM_W-1:0] shifted_full;
  logic [CKS_W-1:0]  cks_in;
  logic [LOG_W-1:0]  msg_head, cks_head;

  dg_ctrl #(
    .LEN1 (LEN1),
    .NDIG (NDIG),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .start  (start),
    .next   (dig_ready),
    .busy   (busy),
    .valid  (dig_valid),
    .idx    (dig_idx),
    .acc_clr(acc_clr),
    .acc_en (acc_en),
    .msg_ld (msg_ld),
    .msg_rot(msg_rot),
    .cks_ld (cks_ld),
    .cks_rot(cks_rot),
    .cks_sel(cks_sel)
  );

  dg_ring #(
    .WIDTH(MSG_W),
    .STEP (LOG_W)
  ) u_msg_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (msg_ld),
    .ld_val(digest),
    .rot   (msg_rot),
    .head  (msg_head)
  );

  dg_csum_acc #(
    .DIG_W  (LOG_W),
    .CSUM_W (CSUM_W),
    .MAX_SUM(CSUM_MAX)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (acc_clr),
    .en     (acc_en),
    .nib    (msg_head),
    .sum_nxt(sum_nxt)
  );

  always_comb begin
    shifted_full = sum_nxt << CSUM_SHIFT;
    cks_in       = CKS_W'(shifted_full >> (CSUM_W - CKS_W));
  end

  dg_ring #(
    .WIDTH(CKS_W),
    .STEP (LOG_W)
  ) u_cks_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (cks_ld),
    .ld_val(cks_in),
    .rot   (cks_rot),
    .head  (cks_head)
  );

  assign dig_data = !dig_valid ? '0 : (cks_sel ? cks_head : msg_head);

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && !dig_ready) |=> $stable(dig_data)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_valid |-> (dig_data == '0 && dig_idx == '0)); // R1

endmodule

// File: tb/sim_wots_basew_digits.sv
module sim_wots_basew_digits;

  localparam int NDIG = 67;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [255:0] digest = '0;
  logic         start = 1'b0;
  logic         busy;
  logic         dig_ready = 1'b0;
  logic         dig_valid;
  logic [3:0]   dig_data;
  logic [6:0]   dig_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wots_basew_digits u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .digest   (digest),
    .start    (start),
    .busy     (busy),
    .dig_ready(dig_ready),
    .dig_valid(dig_valid),
    .dig_data (dig_data),
    .dig_idx  (dig_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dig(input logic [255:0] d, input int i);
    int cs = 0;
    logic [15:0] sh;
    for (int j = 0; j < 64; j++) cs += 15 - int'(d[255-4*j -: 4]);
    sh = 16'(cs) << 4;
    if (i < 64) return d[255-4*i -: 4];
    return sh[15-4*(i-64) -: 4];
  endfunction

  // waits for the first digit; pokes load/start at cycle poke_at (R8)
  task automatic wait_first(input string req, input int poke_at, input logic [255:0] pd);
    int cyc = 0;
    while (!dig_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at + 1) begin load = 1'b0; start = 1'b0; end
      if (cyc == poke_at) begin load = 1'b1; start = 1'b1; digest = pd; end
      if (!dig_valid) check({req, " busy during accumulation"}, int'(busy), 1);
    end
    load = 1'b0; start = 1'b0;
    check({req, " latency"}, cyc, 64);
  endtask

  task automatic kick(input logic [255:0] d, input bit do_load, input bit same);
    @(negedge clk);
    if (do_load) begin digest = d; load = 1'b1; end
    if (do_load && !same) begin
      @(negedge clk);
      load = 1'b0;
    end
    start = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
  endtask

  task automatic drain(input string req, input logic [255:0] d, input bit stall,
                       input int poke_idx, input logic [255:0] pd);
    for (int i = 0; i < NDIG; i++) begin
      check({req, " valid"}, int'(dig_valid), 1);
      check("R6 index", int'(dig_idx), i);
      check(req, int'(dig_data), int'(exp_dig(d, i)));
      if (stall && (i % 3 == 1)) begin
        repeat (2) @(negedge clk);
        check("R6 held data", int'(dig_data), int'(exp_dig(d, i)));
        check("R6 held index", int'(dig_idx), i);
      end
      if (i == poke_idx) begin
        digest = pd; load = 1'b1; start = 1'b1;
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        check("R8 digit after busy load", int'(dig_data), int'(exp_dig(d, i)));
        check("R8 index after busy start", int'(dig_idx), i);
      end
      dig_ready = 1'b1;
      @(negedge clk);
      dig_ready = 1'b0;
    end
    check("R7 valid low after last", int'(dig_valid), 0);
    check("R7 busy low after last", int'(busy), 0);
    check("R1 data zero when idle", int'(dig_data), 0);
    repeat (3) @(negedge clk);
    check("R7 stays idle", int'(dig_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 valid", int'(dig_valid), 0);
    check("R1 idx", int'(dig_idx), 0);
    check("R1 data", int'(dig_data), 0);
  endtask

  task automatic t_run(input string req, input logic [255:0] d, input bit stall);
    kick(d, 1'b1, 1'b0);
    wait_first("R2", -5, '0);
    drain(req, d, stall, -1, '0);
  endtask

  task automatic t_busy_ignore(input logic [255:0] da, input logic [255:0] db);
    kick(da, 1'b1, 1'b0);
    wait_first("R8", 10, db);
    drain("R8", da, 1'b0, 10, db);
  endtask

  task automatic t_replay(input logic [255:0] da);
    kick('0, 1'b0, 1'b0);
    wait_first("R9", -5, '0);
    drain("R9", da, 1'b0, -1, '0);
  endtask

  task automatic t_same(input logic [255:0] dc);
    kick(dc, 1'b1, 1'b1);
    wait_first("R10", -5, '0);
    drain("R10", dc, 1'b0, -1, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] da, db, dc;
    da = {16{16'h0123}} ^ {8{32'h9e3779b9}};
    db = {8{32'hdeadbeef}};
    dc = {16{16'hfedc}} ^ {4{64'h0f1e2d3c4b5a6978}};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run("R3 R5 all-zero digest", '0, 1'b0);
    t_run("R3 R5 all-ones digest", '1, 1'b0);
    t_run("R4 R5 counting pattern", {16{16'h0123}} ^ {16{16'h4567}} ^ {4{64'h0123456789abcdef}}, 1'b1);
    t_busy_ignore(da, db);
    t_replay(da);
    t_same(dc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule